// File: doc/BRIEF.md
# Calibrated Real-Time-Clock Prescaler

This block turns a stream of oscillator enables (nominally 32,768 per second) into a one-cycle pulse per second. It also gives a one-cycle pulse at each minute boundary and a 512 Hz square wave for measuring the oscillator. The oscillator is trimmed digitally rather than by adjusting the crystal. A 5-bit magnitude and a sign choose how many minutes in a 64-minute cycle contain one altered second. On a positive trim that second is cut short by 256 enables. On a negative trim it is stretched by 128 enables. In each case the change falls on the first second of the chosen minute.

The divider is controlled by a small state machine with four states. `ST_HALT` holds the divider while the stop input is high. `ST_PLAIN`, `ST_SHORT` and `ST_LONG` count a nominal, shortened or lengthened second.
- Release (`ST_HALT` to a counting state): stop goes low.
- Halt (any counting state to `ST_HALT`): stop goes high.
- Second end: the divider reaches the last count of the current second. The next state is picked for the position that follows.
- Counter write: the divider is cleared. The state is picked again for the current position.

Picking a state works as follows. If the position is second 0 of a minute whose index is below twice the magnitude, the state is `ST_SHORT` when the sign is 1 and `ST_LONG` when the sign is 0. Otherwise the state is `ST_PLAIN`. The test square wave is taken from a separate free-running counter, before any trimming is applied. It is passed to the output only when the control bits allow it.

Top module: `rtc_cal_prescaler`

## Requirements
- R1: After reset, sec_pulse, min_pulse, ft_bit and ft_out are all 0.
- R2: An unaltered second lasts exactly 2^DIV_W oscillator enables. Clock cycles with osc_tick low are not counted, so a half-rate enable stream doubles the pulse spacing in clock cycles.
- R3: With cal_pos = 1 (speed up), an altered second lasts 2^DIV_W - 256 enables.
- R4: With cal_pos = 0 (slow down), an altered second lasts 2^DIV_W + 128 enables.
- R5: Only second 0 of a minute can be altered. It is altered exactly when that minute's index m (0 to 63) satisfies m < 2*cal_mag. A magnitude of 0 alters nothing, and minutes 62 and 63 are never altered.
- R6: The 6-bit minute index advances once per minute and wraps from 63 to 0, so minute 64 is treated as minute 0.
- R7: min_pulse is high together with the sec_pulse that ends the last second of each minute (every SEC_PER_MIN seconds) and never at any other time.
- R8: While stop is 1, no sec_pulse occurs and ft_out stays 0. The position within the second is kept. After stop returns to 0, a sec_pulse follows within one second plus two cycles.
- R9: A cycle with cnt_load = 1 clears the divider and suppresses any pulse at that edge. The next sec_pulse arrives exactly one second-length of enables later.
- R10: ft_out is a square wave with a period of 64 enables, high for the upper half of a free-running 6-bit count. It is enabled only when stop = 0, ft_bit = 1, afe = 0, and either wds = 1 or wd_zero = 1. In every other case it is 0.
- R11: The ft_out period does not depend on cal_mag or cal_pos.
- R12: ft_bit is loaded from ft_din when ft_wr = 1. It is cleared whenever pwr_down = 1, and pwr_down takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator period |
| cal_mag | input | MAG_W | Trim magnitude (0 to 31) |
| cal_pos | input | 1 | Trim sign: 1 speeds up, 0 slows down |
| stop | input | 1 | Halts the divider and the test counter |
| cnt_load | input | 1 | Time-counter write: restarts the current second |
| ft_wr | input | 1 | Write strobe for the test-enable bit |
| ft_din | input | 1 | Value written to the test-enable bit |
| afe | input | 1 | Alarm-interrupt enable; blocks the test output when 1 |
| wds | input | 1 | Watchdog routed to reset; allows the test output |
| wd_zero | input | 1 | Watchdog register is zero; allows the test output |
| pwr_down | input | 1 | Power-down indication; clears the test-enable bit |
| sec_pulse | output | 1 | One-cycle pulse at each second boundary |
| min_pulse | output | 1 | One-cycle pulse at each minute boundary |
| ft_out | output | 1 | 512 Hz test square wave (gated) |
| ft_bit | output | 1 | Current test-enable bit |

## Verification
A counter write can arrive in the same cycle that the divider reaches the end of a second. Both then want to control the divider and the state register. The bench provokes this case in a run of nominal seconds. It raises cnt_load for exactly the cycle in which the terminal edge is due, and computes that cycle from the timestamp of the previous pulse. The design is correct when no pulse appears at that edge and the next pulse comes one full second after the write. A minute boundary also shares an edge with a second pulse. That case is judged on every pulse of a 129-second run: min_pulse must appear on exactly the odd-numbered pulses.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    typedef enum logic [1:0] {
        ST_HALT  = 2'd0,
        ST_PLAIN = 2'd1,
        ST_SHORT = 2'd2,
        ST_LONG  = 2'd3
    } sec_state_e;

    localparam int unsigned POS_TRIM = 256;
    localparam int unsigned NEG_TRIM = 128;

endpackage

// File: rtl/rtc_min_track.sv
module rtc_min_track #(
    parameter int SEC_PER_MIN = 60,
    parameter int MAG_W       = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_adv,
    input  logic [MAG_W-1:0] cal_mag,
    output logic             mod_now,
    output logic             mod_next,
    output logic             min_pulse,
    output logic [MAG_W:0]   idx
);
    localparam int IDX_W = MAG_W + 1;
    localparam int SEC_W = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

    logic [SEC_W-1:0] sec_q, sec_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic [IDX_W-1:0] span;
    logic             sec_last, min_wrap;

    assign span     = {cal_mag, 1'b0};
    assign sec_last = (sec_q == SEC_W'(SEC_PER_MIN - 1));
    assign min_wrap = sec_adv && sec_last;

    always_comb begin
        sec_d = sec_q;
        idx_d = idx_q;
        if (sec_adv) begin
            sec_d = sec_last ? '0 : sec_q + SEC_W'(1);
        end
        if (min_wrap) begin
            idx_d = idx_q + IDX_W'(1);
        end
    end

    assign mod_now  = (sec_q == '0) && (idx_q < span);
    assign mod_next = (sec_d == '0) && (idx_d < span);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q     <= '0;
            idx_q     <= '0;
            min_pulse <= 1'b0;
        end else begin
            sec_q     <= sec_d;
            idx_q     <= idx_d;
            min_pulse <= min_wrap;
        end
    end

    assign idx = idx_q;

    // R6: the minute index wraps to zero after its last value
    a_r6_idx_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (min_wrap && (idx_q == '1)) |=> (idx_q == '0));

endmodule

// File: rtl/rtc_div_fsm.sv
module rtc_div_fsm
    import rtc_cal_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       stop,
    input  logic       cnt_load,
    input  logic       cal_pos,
    input  logic       mod_now,
    input  logic       mod_next,
    output logic       sec_adv,
    output logic       sec_pulse,
    output sec_state_e state
);
    localparam int CW        = DIV_W + 1;
    localparam int NOM_LEN   = 1 << DIV_W;
    localparam int SHORT_LEN = NOM_LEN - int'(POS_TRIM);
    localparam int LONG_LEN  = NOM_LEN + int'(NEG_TRIM);

    sec_state_e    state_q, state_d;
    logic [CW-1:0] div_q;
    logic [CW-1:0] term;
    logic          running;

    function automatic sec_state_e pick(input logic modified, input logic pos);
        if (!modified) return ST_PLAIN;
        return pos ? ST_SHORT : ST_LONG;
    endfunction

    assign running = (state_q != ST_HALT);

    always_comb begin
        unique case (state_q)
            ST_SHORT: term = CW'(SHORT_LEN - 1);
            ST_LONG:  term = CW'(LONG_LEN - 1);
            ST_HALT,
            ST_PLAIN: term = CW'(NOM_LEN - 1);
        endcase
    end

    assign sec_adv = running && !stop && !cnt_load && tick && (div_q == term);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: begin
                if (!stop) state_d = pick(mod_now, cal_pos);
            end
            ST_PLAIN, ST_SHORT, ST_LONG: begin
                if (stop)          state_d = ST_HALT;
                else if (cnt_load) state_d = pick(mod_now, cal_pos);
                else if (sec_adv)  state_d = pick(mod_next, cal_pos);
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // divider datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (cnt_load) begin
            div_q <= '0;
        end else if (running && !stop && tick) begin
            div_q <= sec_adv ? '0 : div_q + CW'(1);
        end
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n) sec_pulse <= 1'b0;
        else        sec_pulse <= sec_adv;
    end

    assign state = state_q;

    // R8: a held divider produces no second pulse
    a_r8_stop_blocks_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> !sec_pulse);

    // R9: a counter write wins over a terminal count
    a_r9_load_blocks_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> !sec_pulse);

endmodule

// File: rtl/rtc_ft_gen.sv
module rtc_ft_gen #(
    parameter int FT_HALF_LOG2 = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic stop,
    input  logic ft_wr,
    input  logic ft_din,
    input  logic afe,
    input  logic wds,
    input  logic wd_zero,
    input  logic pwr_down,
    output logic ft_out,
    output logic ft_bit
);
    localparam int FW = FT_HALF_LOG2 + 1;

    logic [FW-1:0] ft_cnt;
    logic          gate;

    always_ff @(posedge clk) begin
        if (!rst_n)            ft_cnt <= '0;
        else if (tick && !stop) ft_cnt <= ft_cnt + FW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        ft_bit <= 1'b0;
        else if (pwr_down) ft_bit <= 1'b0;
        else if (ft_wr)    ft_bit <= ft_din;
    end

    assign gate   = !stop && ft_bit && !afe && (wds || wd_zero);
    assign ft_out = gate && ft_cnt[FW-1];

    // R12: power-down leaves the test-enable bit cleared
    a_r12_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !ft_bit);

endmodule

// File: rtl/rtc_cal_prescaler.sv
module rtc_cal_prescaler
    import rtc_cal_pkg::*;
#(
    parameter int DIV_W        = 15,
    parameter int SEC_PER_MIN  = 60,
    parameter int MAG_W        = 5,
    parameter int FT_HALF_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             osc_tick,
    input  logic [MAG_W-1:0] cal_mag,
    input  logic             cal_pos,
    input  logic             stop,
    input  logic             cnt_load,
    input  logic             ft_wr,
    input  logic             ft_din,
    input  logic             afe,
    input  logic             wds,
    input  logic             wd_zero,
    input  logic             pwr_down,
    output logic             sec_pulse,
    output logic             min_pulse,
    output logic             ft_out,
    output logic             ft_bit
);
    localparam int IDX_W = MAG_W + 1;

    logic             sec_adv, mod_now, mod_next;
    logic [IDX_W-1:0] idx;
    sec_state_e       state;

    rtc_div_fsm #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_tick),
        .stop     (stop),
        .cnt_load (cnt_load),
        .cal_pos  (cal_pos),
        .mod_now  (mod_now),
        .mod_next (mod_next),
        .sec_adv  (sec_adv),
        .sec_pulse(sec_pulse),
        .state    (state)
    );

    rtc_min_track #(.SEC_PER_MIN(SEC_PER_MIN), .MAG_W(MAG_W)) u_min (
        .clk      (clk),
        .rst_n    (rst_n),
        .sec_adv  (sec_adv),
        .cal_mag  (cal_mag),
        .mod_now  (mod_now),
        .mod_next (mod_next),
        .min_pulse(min_pulse),
        .idx      (idx)
    );

    rtc_ft_gen #(.FT_HALF_LOG2(FT_HALF_LOG2)) u_ft (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (osc_tick),
        .stop    (stop),
        .ft_wr   (ft_wr),
        .ft_din  (ft_din),
        .afe     (afe),
        .wds     (wds),
        .wd_zero (wd_zero),
        .pwr_down(pwr_down),
        .ft_out  (ft_out),
        .ft_bit  (ft_bit)
    );

    // R5: the last two minutes of the cycle never run an altered second
    a_r5_no_mod_late: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SHORT) || (state == ST_LONG)) |-> (idx < {{MAG_W{1'b1}}, 1'b0}));

    // R7: a minute pulse always coincides with a second pulse
    a_r7_min_has_sec: assert property (@(posedge clk) disable iff (!rst_n)
        min_pulse |-> sec_pulse);

endmodule

// File: tb/rtc_cal_prescaler_bench.sv
`timescale 1ns/1ps
module rtc_cal_prescaler_bench;

    localparam int DIV_W = 9;
    localparam int SPM   = 2;
    localparam int NOM   = 512;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_tick = 1'b1;
    logic       half_rate = 1'b0;
    logic [4:0] cal_mag = '0;
    logic       cal_pos = 1'b0;
    logic       stop = 1'b1;
    logic       cnt_load = 1'b0;
    logic       ft_wr = 1'b0;
    logic       ft_din = 1'b0;
    logic       afe = 1'b0;
    logic       wds = 1'b1;
    logic       wd_zero = 1'b0;
    logic       pwr_down = 1'b0;
    logic       sec_pulse, min_pulse, ft_out, ft_bit;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rel_cyc = 0;
    bit done = 1'b0;

    // mag, pos, expected lengths of seconds 0, 2, 4 (seconds 1 and 3 are nominal)
    localparam logic [35:0] CASES [6] = '{
        {5'd0,  1'b0, 10'd512, 10'd512, 10'd512},
        {5'd0,  1'b1, 10'd512, 10'd512, 10'd512},
        {5'd1,  1'b1, 10'd256, 10'd256, 10'd512},
        {5'd1,  1'b0, 10'd640, 10'd640, 10'd512},
        {5'd2,  1'b1, 10'd256, 10'd256, 10'd256},
        {5'd31, 1'b0, 10'd640, 10'd640, 10'd640}
    };

    rtc_cal_prescaler #(.DIV_W(DIV_W), .SEC_PER_MIN(SPM)) u_rtc_cal_prescaler (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .cal_mag(cal_mag),
        .cal_pos(cal_pos), .stop(stop), .cnt_load(cnt_load), .ft_wr(ft_wr),
        .ft_din(ft_din), .afe(afe), .wds(wds), .wd_zero(wd_zero),
        .pwr_down(pwr_down), .sec_pulse(sec_pulse), .min_pulse(min_pulse),
        .ft_out(ft_out), .ft_bit(ft_bit)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) osc_tick <= half_rate ? ~osc_tick : 1'b1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cnt_load = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rel_cyc = cyc;
    endtask

    task automatic wait_pulse(output int at);
        while (!sec_pulse) @(negedge clk);
        at = cyc;
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic ft_rise(output int at);
        int w = 0;
        logic prev;
        prev = ft_out;
        @(negedge clk);
        while (!(prev == 1'b0 && ft_out == 1'b1) && w < 300) begin
            prev = ft_out;
            @(negedge clk);
            w++;
        end
        at = cyc;
    endtask

    task automatic ft_highs(output int n);
        n = 0;
        for (int i = 0; i < 130; i++) begin
            @(negedge clk);
            if (ft_out) n++;
        end
    endtask

    initial begin
        int p [5];
        int len, a, b, c, n, w;
        string rq;

        // R1: reset state
        do_reset();
        step();
        check(sec_pulse == 1'b0 && min_pulse == 1'b0, "R1", "pulses after reset",
              int'(sec_pulse) + int'(min_pulse), 0);
        check(ft_bit == 1'b0 && ft_out == 1'b0, "R1", "test bit/out after reset",
              int'(ft_bit) + int'(ft_out), 0);

        // table of calibration settings
        stop = 1'b0;
        for (int i = 0; i < 6; i++) begin
            cal_mag = CASES[i][35:31];
            cal_pos = CASES[i][30];
            do_reset();
            for (int k = 0; k < 5; k++) begin
                wait_pulse(p[k]);
                check(min_pulse == (k % 2 == 1), "R7", "min_pulse on pulse",
                      int'(min_pulse), int'(k % 2 == 1));
                step();
            end
            rq = (cal_mag == 0) ? "R2" : (cal_pos ? "R3" : "R4");
            check(p[0] - rel_cyc - 1 == int'(CASES[i][29:20]), rq, "second 0 length",
                  p[0] - rel_cyc - 1, int'(CASES[i][29:20]));
            check(p[2] - p[1] == int'(CASES[i][19:10]), rq, "second 2 length",
                  p[2] - p[1], int'(CASES[i][19:10]));
            check(p[4] - p[3] == int'(CASES[i][9:0]), "R5", "second 4 length",
                  p[4] - p[3], int'(CASES[i][9:0]));
            check(p[1] - p[0] == NOM && p[3] - p[2] == NOM, "R5", "second 1/3 length",
                  p[3] - p[2], NOM);
        end

        // R2: half-rate enables
        cal_mag = '0;
        half_rate = 1'b1;
        wait_pulse(a); step();
        wait_pulse(b); step();
        check(b - a == 2 * NOM, "R2", "half-rate spacing", b - a, 2 * NOM);
        half_rate = 1'b0;
        wait_pulse(a); step();

        // R9: counter write mid-second
        wait_pulse(a); step();
        repeat (100) step();
        c = cyc;
        cnt_load = 1'b1;
        step();
        cnt_load = 1'b0;
        wait_pulse(b); step();
        check(b == c + 1 + NOM, "R9", "pulse after mid write", b, c + 1 + NOM);

        // R9: counter write on the terminal edge
        wait_pulse(a); step();
        while (cyc != a + NOM - 1) step();
        cnt_load = 1'b1;
        step();
        cnt_load = 1'b0;
        check(sec_pulse == 1'b0, "R9", "pulse suppressed at write", int'(sec_pulse), 0);
        wait_pulse(b); step();
        check(b == a + 2 * NOM, "R9", "pulse after terminal write", b, a + 2 * NOM);

        // R8: stop holds the divider
        repeat (37) step();
        stop = 1'b1;
        n = 0;
        for (int i = 0; i < 1500; i++) begin
            step();
            if (sec_pulse) n++;
        end
        check(n == 0, "R8", "pulses while stopped", n, 0);
        stop = 1'b0;
        w = 0;
        while (!sec_pulse && w < 600) begin step(); w++; end
        check(sec_pulse && w <= NOM + 2, "R8", "cycles to resume pulse", w, NOM + 2);

        // test output
        do_reset();
        ft_din = 1'b1; ft_wr = 1'b1;
        step();
        ft_wr = 1'b0;
        check(ft_bit == 1'b1, "R12", "test bit written", int'(ft_bit), 1);
        afe = 1'b0; wds = 1'b1; wd_zero = 1'b0;
        ft_rise(a); ft_rise(b);
        check(b - a == 64, "R10", "test period", b - a, 64);
        cal_mag = 5'd31; cal_pos = 1'b1;
        ft_rise(a); ft_rise(b);
        check(b - a == 64, "R11", "test period, trim +31", b - a, 64);
        cal_pos = 1'b0;
        ft_rise(a); ft_rise(b);
        check(b - a == 64, "R11", "test period, trim -31", b - a, 64);
        afe = 1'b1;
        ft_highs(n);
        check(n == 0, "R10", "test out with afe", n, 0);
        afe = 1'b0; wds = 1'b0;
        ft_highs(n);
        check(n == 0, "R10", "test out, watchdog to irq", n, 0);
        wd_zero = 1'b1;
        ft_highs(n);
        check(n > 0, "R10", "test out with zero watchdog", n, 1);
        stop = 1'b1;
        ft_highs(n);
        check(n == 0, "R8", "test out while stopped", n, 0);
        stop = 1'b0;
        pwr_down = 1'b1; ft_wr = 1'b1; ft_din = 1'b1;
        step();
        pwr_down = 1'b0; ft_wr = 1'b0;
        check(ft_bit == 1'b0, "R12", "power-down over write", int'(ft_bit), 0);
        ft_highs(n);
        check(n == 0, "R12", "test out after power-down", n, 0);

        // R5/R6: full 64-minute cycle and wrap at magnitude 31
        cal_mag = 5'd31; cal_pos = 1'b1;
        do_reset();
        a = rel_cyc;
        for (int k = 0; k <= 128; k++) begin
            int exp;
            wait_pulse(b);
            len = (k == 0) ? (b - a - 1) : (b - a);
            exp = ((k % 2 == 0) && ((k / 2) % 64 < 62)) ? NOM - 256 : NOM;
            check(len == exp, (k >= 128) ? "R6" : "R5", "cycle second length", len, exp);
            check(min_pulse == (k % 2 == 1), "R7", "min_pulse in cycle",
                  int'(min_pulse), int'(k % 2 == 1));
            a = b;
            step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule